// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns the programmed state of one memory-protection entry into an inclusive byte range. It reads the entry's 8-bit config byte, the entry's address register and the address register of the entry just below it. From these it produces a start address and an end address. Both address registers hold a byte address divided by four. The outputs are therefore two bits wider than the registers, so a shifted value is never truncated.

The block is purely combinational. It can be instantiated once per entry, or a single copy can be shared while a sequencer steps through the entries. In the shared case the `first_entry_i` input tells the decoder that no lower neighbour exists.

Naturally aligned power-of-two regions are sized by counting the trailing ones of the address register. The range of a top-of-range region comes from the lower neighbour's register. Permission checks and register storage live elsewhere.

Top module: `region_bounds_decoder`

## Requirements
- R1: The match mode is taken from config bits [4:3]: code 0 disables the entry, code 1 selects top-of-range, code 2 selects a 4-byte region, and code 3 selects a naturally aligned power-of-two region. `active_o` is 1 exactly when the code is not 0.
- R2: With mode code 0, `lo_o` is 0, `hi_o` is all ones, and `active_o` is 0.
- R3: With mode code 1, `lo_o` equals the lower neighbour's register times 4, and `hi_o` equals this entry's register times 4, minus 1.
- R4: With mode code 1 and an address register of zero, `hi_o` wraps to all ones across the full output width.
- R5: When `first_entry_i` is 1, the lower neighbour's register is treated as zero, so in mode code 1 `lo_o` is 0 whatever `prev_addr_i` holds.
- R6: With mode code 2, `lo_o` equals the address register times 4, and `hi_o` equals `lo_o` plus 3.
- R7: With mode code 3, let t be the number of trailing ones in the address register. `lo_o` is the register with its low t bits cleared, times 4, and `hi_o` is `lo_o` plus 2^(t+3) minus 1.
- R8: With mode code 3 and an address register of all ones, `lo_o` is 0 and `hi_o` is all ones. A register whose only zero is its top bit yields the same whole-space range.
- R9: Config bits 0 to 2 and 5 to 7 have no effect on any output.
- R10: In mode codes 0, 2 and 3, `prev_addr_i` and `first_entry_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_i | input | 8 | Entry config byte; bits [4:3] select the mode |
| addr_i | input | XLEN | This entry's address register (byte address / 4) |
| prev_addr_i | input | XLEN | Lower neighbour's address register |
| first_entry_i | input | 1 | High when the entry has no lower neighbour |
| lo_o | output | XLEN+2 | Inclusive start byte address |
| hi_o | output | XLEN+2 | Inclusive end byte address |
| active_o | output | 1 | Entry takes part in matching |

## Verification
The bench walks the trailing-ones count through every boundary. It covers zero ones, a single one, a zero only in the top bit, and all ones. A design with an off-by-one in the priority encoder would report regions that are half or double their size. A design that mishandled the all-ones case would return a small region near the top of memory instead of the whole space.

Top-of-range with a zero register checks the end-address wrap. A narrower subtraction would produce a truncated end address. The bench also toggles `first_entry_i`, `prev_addr_i` and the unused config bits in every mode. A decoder that let any of these leak into the result would show a changed bound.

// File: rtl/region_bounds_decoder.sv
module region_bounds_decoder #(
  parameter int XLEN = 32
) (
  input  logic [7:0]        cfg_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic [XLEN-1:0]   prev_addr_i,
  input  logic              first_entry_i,
  output logic [XLEN+1:0]   lo_o,
  output logic [XLEN+1:0]   hi_o,
  output logic              active_o
);
  localparam int OW = XLEN + 2;
  localparam int TW = $clog2(XLEN + 1);

  logic [1:0]      mode;
  logic [XLEN-1:0] below;
  logic [OW-1:0]   scaled;
  logic [OW-1:0]   tor_lo, tor_hi;
  logic [OW-1:0]   pot_mask, pot_lo, pot_hi;
  logic [TW-1:0]   ones;

  assign mode   = cfg_i[4:3];
  assign below  = first_entry_i ? '0 : prev_addr_i;
  assign scaled = {addr_i, 2'b00};

  assign tor_lo = {below, 2'b00};
  assign tor_hi = scaled - OW'(1);

  always_comb begin
    ones = TW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--)
      if (!addr_i[i]) ones = TW'(i);
  end

  always_comb begin
    for (int i = 0; i < OW; i++)
      pot_mask[i] = (i < int'(ones) + 3);
  end

  assign pot_lo = scaled & ~pot_mask;
  assign pot_hi = pot_lo | pot_mask;

  always_comb begin
    active_o = 1'b1;
    case (mode)
      2'd1: begin
        lo_o = tor_lo;
        hi_o = tor_hi;
      end
      2'd2: begin
        lo_o = scaled;
        hi_o = {addr_i, 2'b11};
      end
      2'd3: begin
        lo_o = pot_lo;
        hi_o = pot_hi;
      end
      default: begin
        lo_o     = '0;
        hi_o     = '1;
        active_o = 1'b0;
      end
    endcase
  end
endmodule

module region_bounds_decoder_chk #(
  parameter int XLEN = 32
) (
  input logic [7:0]      cfg_i,
  input logic [XLEN-1:0] addr_i,
  input logic            first_entry_i,
  input logic [XLEN+1:0] lo_o,
  input logic [XLEN+1:0] hi_o,
  input logic            active_o
);
  localparam int OW = XLEN + 2;
  logic [OW-1:0] span;
  assign span = hi_o - lo_o;

  always_comb begin
    if (!active_o) begin
      p_off_whole_r2: assert (lo_o == '0 && hi_o == '1 && cfg_i[4:3] == 2'd0)
        else $error("inactive entry has wrong bounds");
    end
    if (cfg_i[4:3] != 2'd0) begin
      p_active_r1: assert (active_o) else $error("enabled entry not active");
    end
    if (cfg_i[4:3] == 2'd1) begin
      p_tor_end_r3: assert (hi_o + OW'(1) == {addr_i, 2'b00})
        else $error("top-of-range end mismatch");
      if (first_entry_i) begin
        p_first_base_r5: assert (lo_o == '0) else $error("first entry base not zero");
      end
    end
    if (cfg_i[4:3] == 2'd2) begin
      p_na4_size_r6: assert (span == OW'(3) && lo_o[1:0] == 2'b00)
        else $error("4-byte region malformed");
    end
    if (cfg_i[4:3] == 2'd3) begin
      p_pot_aligned_r7: assert (((span & (span + OW'(1))) == '0) && ((lo_o & span) == '0))
        else $error("power-of-two region malformed");
    end
  end
endmodule

bind region_bounds_decoder region_bounds_decoder_chk #(.XLEN(XLEN)) u_chk (
  .cfg_i(cfg_i), .addr_i(addr_i), .first_entry_i(first_entry_i),
  .lo_o(lo_o), .hi_o(hi_o), .active_o(active_o)
);

// File: tb/region_bounds_decoder_test.sv
module region_bounds_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam longint unsigned OMASK = (64'd1 << (XLEN + 2)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg = '0;
  logic [XLEN-1:0] addr = '0, prev = '0;
  logic first = 1'b0;
  logic [XLEN+1:0] lo, hi;
  logic active;
  int checks = 0, failures = 0;
  bit done = 0;

  region_bounds_decoder #(.XLEN(XLEN)) uut (
    .cfg_i(cfg), .addr_i(addr), .prev_addr_i(prev), .first_entry_i(first),
    .lo_o(lo), .hi_o(hi), .active_o(active)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic model(input logic [7:0] c, input longint unsigned a, input longint unsigned p,
                       input bit f, output longint unsigned elo, output longint unsigned ehi,
                       output bit eact);
    int m = (c >> 3) & 3;
    int t = 0;
    while (t < XLEN && a[t]) t++;
    eact = (m != 0);
    case (m)
      1: begin elo = (f ? 0 : p) << 2; ehi = ((a << 2) - 1) & OMASK; end
      2: begin elo = a << 2; ehi = elo + 3; end
      3: begin
        if (t == XLEN) begin elo = 0; ehi = OMASK; end
        else begin elo = ((a >> t) << t) << 2; ehi = elo + (64'd1 << (t + 3)) - 1; end
      end
      default: begin elo = 0; ehi = OMASK; end
    endcase
  endtask

  task automatic compare(input string req);
    longint unsigned elo, ehi;
    bit eact;
    model(cfg, longint'(addr), longint'(prev), first, elo, ehi, eact);
    checks++;
    if (longint'(lo) != elo || longint'(hi) != ehi || active != eact) begin
      failures++;
      $display("FAIL %s cfg=%h addr=%h prev=%h first=%0d: got lo=%h hi=%h act=%0d exp lo=%h hi=%h act=%0d",
               req, cfg, addr, prev, first, lo, hi, active, elo, ehi, eact);
    end
  endtask

  task automatic apply(input logic [7:0] c, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] p, input bit f, input string req);
    @(posedge clk);
    cfg = c; addr = a; prev = p; first = f;
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R2 reset");
    rst = 1'b0;
    apply(8'h08, 32'h0000_1000, 32'h0000_0400, 0, "R3");
    apply(8'h08, 32'h0000_0000, 32'h0000_0400, 0, "R4");
    apply(8'h08, 32'h0000_2000, 32'h0000_0400, 1, "R5");
    apply(8'h10, 32'h1234_5678, 32'hFFFF_0000, 0, "R6");
    apply(8'h10, 32'hFFFF_FFFF, 32'h0, 0, "R6");
    apply(8'h18, 32'h0000_1000, 32'h0, 0, "R7");
    apply(8'h18, 32'h0000_1001, 32'h0, 0, "R7");
    apply(8'h18, 32'h0000_10FF, 32'h0, 0, "R7");
    apply(8'h18, 32'hBFFF_FFFF, 32'h0, 0, "R7");
    apply(8'h18, 32'hFFFF_FFFF, 32'h0, 0, "R8");
    apply(8'h18, 32'h7FFF_FFFF, 32'h0, 0, "R8");
    apply(8'h00, 32'h1234_5678, 32'h1111_1111, 0, "R2");
    apply(8'hE7, 32'h1234_5678, 32'h1111_1111, 1, "R9");
    apply(8'hEF, 32'h0000_1000, 32'h0000_0400, 0, "R9");
    apply(8'hF7, 32'h0000_0ABC, 32'h0, 0, "R9");
    apply(8'h7F, 32'h0000_10FF, 32'h0, 0, "R9");
    apply(8'h10, 32'h0000_0040, 32'hDEAD_BEEF, 1, "R10");
    apply(8'h18, 32'h0000_0043, 32'hDEAD_BEEF, 1, "R10");
    apply(8'h00, 32'h0000_0043, 32'hDEAD_BEEF, 1, "R10");
    for (int k = 0; k < XLEN; k++)
      apply(8'h18, (32'h1 << k) - 1, 32'h0, 0, "R7");
    for (int k = 0; k < 400; k++) begin
      logic [7:0] c = 8'($urandom());
      string tag;
      case (c[4:3])
        2'd0: tag = "R2"; 2'd1: tag = "R3"; 2'd2: tag = "R6"; default: tag = "R7";
      endcase
      apply(c, $urandom(), $urandom(), bit'($urandom() & 1), tag);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule